// File: doc/BRIEF.md
# PWM Duty Demand and Standby Detector

This block turns an external speed-command PWM signal into a 9-bit speed demand for a motor drive. It cleans the pin with a glitch filter, measures high time and period in system clock ticks, and divides the two to get a demand from 0 to 511. The measurement works over any input period from a few clock ticks up to a configurable timeout, so a single instance covers input rates from about 100 Hz to 100 kHz at a 50 MHz clock.

A drive-enable flag follows the demand with hysteresis. It turns on above about 10 % duty and turns off below about 7.4 % duty, so a command that sits near the threshold cannot make the drive chatter. The block also manages a low-power standby state. It enters standby after reset and whenever the pin stays low longer than a lock off-time, which software supplies as a tick count. It leaves standby when a high pulse of a minimum length arrives. The demand is a plain level output. It holds its last value until the next measurement, so there is no handshake or back-pressure.

Top module: `pwm_duty_demand`

## Requirements
- R1: While reset is asserted and right after it is released, `standby` is 1, `demand` is 0 and `drive_enable` is 0.
- R2: At each rising edge of the filtered pin, when a full period has been seen since the previous rising edge, `demand` becomes floor(H*511/P). H is the number of high ticks and P is the number of ticks in that period. `demand` changes on no other occasion except R5.
- R3: A new demand greater than 51 sets `drive_enable`. A new demand less than 38 clears it. A new demand from 38 to 51 inclusive leaves it unchanged.
- R4: A level change on `pwm_in` that lasts fewer than FILT_LEN clock cycles has no effect on the measurement, the enable or the standby state.
- R5: When no filtered rising edge occurs for PERIOD_MAX cycles, `demand` becomes 511 if the filtered pin is high and 0 if it is low. This report repeats every PERIOD_MAX cycles until an edge arrives.
- R6: When the filtered pin stays low for more than `lock_off_ticks` consecutive cycles, `standby` becomes 1.
- R7: In standby, a filtered high pulse lasting MIN_PULSE consecutive cycles clears `standby`. A shorter pulse leaves it set.
- R8: `drive_enable` is 0 from the cycle after `standby` is 1, for as long as standby lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Speed-command pin, already synchronized to `clk` |
| lock_off_ticks | input | LOCK_W | Low time in ticks that triggers standby; held constant in use |
| demand | output | 9 | Speed demand, 0 to 511 |
| drive_enable | output | 1 | Drive enable with hysteresis |
| standby | output | 1 | Standby state flag |

## Verification
A pin edge reaches the filtered level FILT_LEN cycles after it appears. `demand` updates one cycle after the filtered rising edge, and `drive_enable` follows one cycle later. Standby is set about `lock_off_ticks`+FILT_LEN+1 cycles into a low stretch, and it clears FILT_LEN+MIN_PULSE cycles after a long high starts. The bench plays at least three whole periods of each pattern and checks all outputs at a falling clock edge at the end of the last period. By then the newest measurement is many cycles old and covers a period made entirely of the new pattern. The standby tests wait well past each of these latencies, or stop clearly short of them, before they sample.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  localparam int DEM_W   = 9;
  localparam int DEM_MAX = (1 << DEM_W) - 1;
  typedef logic [DEM_W-1:0] demand_t;
endpackage

// File: rtl/pdd_glitch_filter.sv
module pdd_glitch_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic filt_out
);
  localparam int FC_W = $clog2(FILT_LEN + 1);

  logic [FC_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_out <= 1'b0;
      run_cnt  <= '0;
    end else if (raw_in == filt_out) begin
      run_cnt <= '0;
    end else if (run_cnt == FC_W'(FILT_LEN - 1)) begin
      filt_out <= raw_in;
      run_cnt  <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_FILT_RISE_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_out) |-> $past(raw_in)); // R4
  AST_FILT_FALL_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_out) |-> !$past(raw_in)); // R4
endmodule

// File: rtl/pdd_duty_meter.sv
module pdd_duty_meter
  import pdd_pkg::*;
#(
  parameter int PERIOD_MAX = 600000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lvl,
  output demand_t demand,
  output logic    meas_vld
);
  localparam int CNT_W = $clog2(PERIOD_MAX + 1);
  localparam int PW    = CNT_W + DEM_W;

  logic [CNT_W-1:0] per_cnt, hi_cnt;
  logic             lvl_d, armed, rise;
  logic [PW-1:0]    prod, quot;

  assign rise = lvl & ~lvl_d;
  assign prod = {hi_cnt, {DEM_W{1'b0}}} - PW'(hi_cnt);
  assign quot = (per_cnt == '0) ? '0 : prod / PW'(per_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt  <= '0;
      hi_cnt   <= '0;
      lvl_d    <= 1'b0;
      armed    <= 1'b0;
      demand   <= '0;
      meas_vld <= 1'b0;
    end else begin
      lvl_d    <= lvl;
      meas_vld <= 1'b0;
      if (rise) begin
        if (armed) begin
          demand   <= (quot > PW'(DEM_MAX)) ? demand_t'(DEM_MAX) : quot[DEM_W-1:0];
          meas_vld <= 1'b1;
        end
        armed   <= 1'b1;
        per_cnt <= CNT_W'(1);
        hi_cnt  <= CNT_W'(1);
      end else if (per_cnt == CNT_W'(PERIOD_MAX - 1)) begin
        demand   <= lvl ? demand_t'(DEM_MAX) : '0;
        meas_vld <= 1'b1;
        armed    <= 1'b0;
        per_cnt  <= '0;
        hi_cnt   <= '0;
      end else begin
        per_cnt <= per_cnt + 1'b1;
        hi_cnt  <= hi_cnt + CNT_W'(lvl);
      end
    end
  end

  AST_DEMAND_ONLY_ON_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(demand) |-> meas_vld); // R2
  AST_TIMEOUT_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && !armed && lvl_d) |-> (demand == demand_t'(DEM_MAX))); // R5
endmodule

// File: rtl/pdd_enable_hyst.sv
module pdd_enable_hyst
  import pdd_pkg::*;
#(
  parameter int ON_TH  = 51,
  parameter int OFF_TH = 38
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    meas_vld,
  input  demand_t meas_dem,
  input  logic    standby,
  output logic    enable
);
  localparam demand_t ON_V  = demand_t'(ON_TH);
  localparam demand_t OFF_V = demand_t'(OFF_TH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
    end else if (standby) begin
      enable <= 1'b0;
    end else if (meas_vld) begin
      if (meas_dem > ON_V)       enable <= 1'b1;
      else if (meas_dem < OFF_V) enable <= 1'b0;
    end
  end

  AST_HYST_TURN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && meas_dem > ON_V && !standby) |=> enable); // R3
  AST_HYST_TURN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && meas_dem < OFF_V) |=> !enable); // R3
  AST_HYST_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && meas_dem >= OFF_V && meas_dem <= ON_V && !standby) |=> $stable(enable)); // R3
endmodule

// File: rtl/pdd_standby_ctrl.sv
module pdd_standby_ctrl #(
  parameter int LOCK_W    = 28,
  parameter int MIN_PULSE = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic [LOCK_W-1:0] lock_off_ticks,
  output logic              standby
);
  localparam int HC_W = $clog2(MIN_PULSE + 1);

  logic [LOCK_W-1:0] low_cnt;
  logic [HC_W-1:0]   high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      standby  <= 1'b1;
    end else begin
      if (lvl)                          low_cnt <= '0;
      else if (low_cnt != lock_off_ticks) low_cnt <= low_cnt + 1'b1;

      if (!lvl)                                high_cnt <= '0;
      else if (high_cnt != HC_W'(MIN_PULSE))   high_cnt <= high_cnt + 1'b1;

      if (!lvl && low_cnt == lock_off_ticks)
        standby <= 1'b1;
      else if (lvl && high_cnt == HC_W'(MIN_PULSE - 1))
        standby <= 1'b0;
    end
  end

  AST_STBY_ENTER_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> !$past(lvl)); // R6
  AST_STBY_EXIT_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |-> $past(lvl)); // R7
endmodule

// File: rtl/pwm_duty_demand.sv
module pwm_duty_demand
  import pdd_pkg::*;
#(
  parameter int PERIOD_MAX = 600000,
  parameter int FILT_LEN   = 8,
  parameter int MIN_PULSE  = 50,
  parameter int LOCK_W     = 28,
  parameter int ON_TH      = 51,
  parameter int OFF_TH     = 38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [LOCK_W-1:0] lock_off_ticks,
  output logic [DEM_W-1:0]  demand,
  output logic              drive_enable,
  output logic              standby
);
  logic    pin_f;
  logic    meas_vld;
  demand_t dem_q;

  pdd_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_in(pwm_in), .filt_out(pin_f)
  );

  pdd_duty_meter #(.PERIOD_MAX(PERIOD_MAX)) u_meter (
    .clk(clk), .rst_n(rst_n), .lvl(pin_f), .demand(dem_q), .meas_vld(meas_vld)
  );

  pdd_enable_hyst #(.ON_TH(ON_TH), .OFF_TH(OFF_TH)) u_hyst (
    .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas_dem(dem_q),
    .standby(standby), .enable(drive_enable)
  );

  pdd_standby_ctrl #(.LOCK_W(LOCK_W), .MIN_PULSE(MIN_PULSE)) u_stby (
    .clk(clk), .rst_n(rst_n), .lvl(pin_f), .lock_off_ticks(lock_off_ticks),
    .standby(standby)
  );

  assign demand = dem_q;

  AST_NO_DRIVE_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !drive_enable); // R8
endmodule

// File: tb/tb_pwm_duty_demand.sv
`timescale 1ns/1ps
module tb_pwm_duty_demand;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm_in = 1'b0;
  logic [15:0] lock_off_ticks = 16'd5000;
  logic [8:0]  demand;
  logic        drive_enable, standby;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_duty_demand #(.PERIOD_MAX(3000), .FILT_LEN(4), .MIN_PULSE(8), .LOCK_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .lock_off_ticks(lock_off_ticks),
    .demand(demand), .drive_enable(drive_enable), .standby(standby)
  );

  // columns: high ticks, period ticks, expected demand, expected enable
  localparam int NV = 11;
  localparam int VEC [NV][4] = '{
    '{100,  200, 255, 1},
    '{20,   200, 51,  1},
    '{16,   200, 40,  1},
    '{14,   200, 35,  0},
    '{16,   200, 40,  0},
    '{21,   200, 53,  1},
    '{50,   100, 255, 1},
    '{300,  400, 383, 1},
    '{1000, 2000, 255, 1},
    '{190,  200, 485, 1},
    '{5,    200, 12,  0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input bit lv, input int n);
    pwm_in = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic play(input int hi, input int per, input int nper);
    for (int k = 0; k < nper; k++) begin
      hold(1'b1, hi);
      hold(1'b0, per - hi);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 standby in reset", int'(standby), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 standby after reset", int'(standby), 1);
    chk("R1 demand after reset", int'(demand), 0);
    chk("R1 enable after reset", int'(drive_enable), 0);

    // R2 R3 table walk; enable column follows the hysteresis history
    for (int i = 0; i < NV; i++) begin
      play(VEC[i][0], VEC[i][1], 3);
      chk($sformatf("R2 demand vec %0d", i), int'(demand), VEC[i][2]);
      chk($sformatf("R3 enable vec %0d", i), int'(drive_enable), VEC[i][3]);
    end
    chk("R7 standby left by long pulse", int'(standby), 0);

    // R4: 2-cycle spike inside low phase of a 14/200 pattern
    for (int k = 0; k < 3; k++) begin
      hold(1'b1, 14);
      hold(1'b0, 50);
      hold(1'b1, 2);
      hold(1'b0, 134);
    end
    chk("R4 spike ignored, demand", int'(demand), 35);
    chk("R4 spike ignored, enable", int'(drive_enable), 0);

    // R5: constant high
    hold(1'b1, 3500);
    chk("R5 full duty demand", int'(demand), 511);
    chk("R3 full duty enables", int'(drive_enable), 1);

    // R5: constant low, still short of the lock off-time
    hold(1'b0, 3500);
    chk("R5 zero duty demand", int'(demand), 0);
    chk("R3 zero duty disables", int'(drive_enable), 0);
    chk("R6 no standby before off-time", int'(standby), 0);

    hold(1'b0, 2000);
    chk("R6 standby after long low", int'(standby), 1);
    chk("R8 enable off in standby", int'(drive_enable), 0);

    // R7: pulses too short to leave standby
    hold(1'b1, 2);
    hold(1'b0, 30);
    chk("R4 filtered pulse keeps standby", int'(standby), 1);
    hold(1'b1, 6);
    hold(1'b0, 30);
    chk("R7 short pulse keeps standby", int'(standby), 1);
    chk("R8 enable off during standby", int'(drive_enable), 0);
    hold(1'b1, 12);
    hold(1'b0, 10);
    chk("R7 long pulse leaves standby", int'(standby), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule